// File: doc/BRIEF.md
# EEPROM Write-Protection and Status Logic

This block holds the status register of a serial EEPROM and decides, cycle by cycle, whether an array write or a status write may go ahead. A serial front end decodes the instructions and presents one-cycle requests to the block. These requests are write-enable, write-disable, status write with its data byte, and array write with its target address. The front end also gives the block the level of the active-low write-protect pin and a busy flag from the write timer. The block answers with two combinational allow flags and a status byte that the front end shifts out on a status read.

Three mechanisms combine to guard the memory. The first is a software write-enable latch that every write needs and that each accepted write consumes. The second is a two-bit protection level that makes the top quarter, the top half or all of the address space read-only. The third is a lock-enable bit that arms the hardware pin. When the lock-enable bit is clear, the pin has no effect at all, so the status register stays writable even with the pin tied low. The protection level and the lock-enable bit come out of reset from parameters, which stand in for their non-volatile copies. Serial shifting and the storage array itself are handled elsewhere.

Top module: `eeprom_wrguard`

## Requirements
- R1: In reset and on the first cycle after it, the write-enable latch is clear. The protection level equals parameter RST_LVL and the lock-enable bit equals parameter RST_LOCK.
- R2: The status byte is laid out as follows. Bit 0 is the busy input. Bit 1 is the write-enable latch. Bits 3:2 are the protection level. Bit 7 is the lock-enable bit. Bits 6:4 always read 0.
- R3: A write-enable request sets the latch on the next cycle, and a write-disable request clears it. When both come in the same cycle, the write-disable request wins. While busy is high, both requests are ignored.
- R4: The array-write allow flag is high exactly when an array write is requested, the latch is set, busy is low and the target address is not protected.
- R5: Protection level 00 protects nothing. Level 01 protects the top quarter of the address space (top two address bits 11). Level 10 protects the top half (top address bit 1). Level 11 protects every address.
- R6: The status-write allow flag is high exactly when a status write is requested, the latch is set, busy is low and the pin is not locking. The pin locks only when the lock-enable bit is 1 and wp_n is 0. With lock-enable at 0, wp_n has no effect.
- R7: On the cycle after an accepted status write, the protection level equals data bits 3:2 and the lock-enable bit equals data bit 7. All other data bits are ignored. Both fields hold their values at all other times.
- R8: Every accepted write, array or status, clears the write-enable latch on the next cycle. A refused write leaves the latch unchanged.
- R9: While busy is high, both allow flags are low and status bit 0 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wren_req | input | 1 | Write-enable instruction decoded this cycle |
| wrdi_req | input | 1 | Write-disable instruction decoded this cycle |
| stat_wr_req | input | 1 | Status-write instruction decoded this cycle |
| stat_wr_data | input | 8 | Data byte of the status write |
| arr_wr_req | input | 1 | Array write pending this cycle |
| arr_addr | input | ADDR_W (14) | Target address of the array write |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Internal write cycle in progress |
| status_byte | output | 8 | Status byte for readback |
| arr_wr_ok | output | 1 | Array write allowed |
| stat_wr_ok | output | 1 | Status write allowed |

## Verification
The assertions assume the front end never raises a status-write request and an array-write request in the same cycle. The bench keeps all its stimulus within that rule, both in the directed phases and in the random phase, by choosing one write kind per cycle. The assertions also assume that requests last one cycle each. They take busy as an arbitrary level, so the stimulus toggles busy freely, including in cycles where requests are present.

// File: rtl/eeprom_wrguard_pkg.sv
package eeprom_wrguard_pkg;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_lvl_e;

  localparam int STAT_W      = 8;
  localparam int BIT_BUSY    = 0;
  localparam int BIT_WEL     = 1;
  localparam int BIT_LVL_LO  = 2;
  localparam int BIT_LVL_HI  = 3;
  localparam int BIT_LOCK    = 7;

  // Decide whether the two most significant address bits fall in a protected region (R5)
  function automatic logic region_locked(input prot_lvl_e lvl, input logic [1:0] top2);
    logic hit;
    case (lvl)
      PROT_NONE:    hit = 1'b0;
      PROT_QUARTER: hit = (top2 == 2'b11);
      PROT_HALF:    hit = top2[1];
      default:      hit = 1'b1;
    endcase
    return hit;
  endfunction

  // Assemble the readback byte (R2)
  function automatic logic [STAT_W-1:0] pack_status(input logic busy, input logic wel,
                                                    input prot_lvl_e lvl, input logic lock);
    logic [STAT_W-1:0] s;
    s = '0;
    s[BIT_BUSY] = busy;
    s[BIT_WEL]  = wel;
    s[BIT_LVL_HI:BIT_LVL_LO] = lvl;
    s[BIT_LOCK] = lock;
    return s;
  endfunction

endpackage

// File: rtl/wrguard_latch.sv
module wrguard_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic busy,
  input  logic consume,
  output logic wel
);

  logic do_clr;
  logic do_set;

  assign do_clr = consume | (clr_req & ~busy);
  assign do_set = set_req & ~clr_req & ~busy & ~consume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel <= 1'b0;
    else if (do_clr) wel <= 1'b0;
    else if (do_set) wel <= 1'b1;
  end

  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !clr_req && !busy && !consume) |=> wel);                  // R3
  AST_WEL_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !busy) |=> !wel);                                         // R3
  AST_WEL_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !consume) |=> $stable(wel));                                 // R3
  AST_WEL_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !wel);                                                    // R8

endmodule

// File: rtl/wrguard_cfg.sv
module wrguard_cfg
  import eeprom_wrguard_pkg::*;
#(
  parameter prot_lvl_e RST_LVL  = PROT_NONE,
  parameter logic      RST_LOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STAT_W-1:0] din,
  output prot_lvl_e         lvl,
  output logic              lock_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= RST_LVL;
      lock_en <= RST_LOCK;
    end else if (load) begin
      lvl     <= prot_lvl_e'(din[BIT_LVL_HI:BIT_LVL_LO]);
      lock_en <= din[BIT_LOCK];
    end
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lvl == prot_lvl_e'($past(din[BIT_LVL_HI:BIT_LVL_LO]))
              && lock_en == $past(din[BIT_LOCK])));                       // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(lvl) && $stable(lock_en)));                        // R7

endmodule

// File: rtl/wrguard_region.sv
module wrguard_region
  import eeprom_wrguard_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr,
  input  prot_lvl_e         lvl,
  output logic              locked
);

  localparam int MSB = ADDR_W - 1;

  always_comb locked = region_locked(lvl, addr[MSB -: 2]);

endmodule

// File: rtl/eeprom_wrguard.sv
module eeprom_wrguard
  import eeprom_wrguard_pkg::*;
#(
  parameter int        ADDR_W   = 14,
  parameter prot_lvl_e RST_LVL  = PROT_NONE,
  parameter logic      RST_LOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_req,
  input  logic              wrdi_req,
  input  logic              stat_wr_req,
  input  logic [7:0]        stat_wr_data,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              wp_n,
  input  logic              busy,
  output logic [7:0]        status_byte,
  output logic              arr_wr_ok,
  output logic              stat_wr_ok
);

  logic      wel;
  logic      lock_en;
  prot_lvl_e lvl;
  logic      addr_locked;
  logic      pin_lock;
  logic      consume;

  wrguard_cfg #(.RST_LVL(RST_LVL), .RST_LOCK(RST_LOCK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(stat_wr_ok), .din(stat_wr_data),
    .lvl(lvl), .lock_en(lock_en)
  );

  wrguard_region #(.ADDR_W(ADDR_W)) u_region (
    .addr(arr_addr), .lvl(lvl), .locked(addr_locked)
  );

  wrguard_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_req(wren_req), .clr_req(wrdi_req),
    .busy(busy), .consume(consume), .wel(wel)
  );

  assign pin_lock    = lock_en & ~wp_n;
  assign stat_wr_ok  = stat_wr_req & wel & ~busy & ~pin_lock;
  assign arr_wr_ok   = arr_wr_req & wel & ~busy & ~addr_locked;
  assign consume     = stat_wr_ok | arr_wr_ok;
  assign status_byte = pack_status(busy, wel, lvl, lock_en);

  AST_ARR_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok |-> (wel && arr_wr_req));                                   // R4
  AST_STAT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_ok |-> (wel && stat_wr_req));                                 // R6
  AST_PIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en && !wp_n) |-> !stat_wr_ok);                                  // R6
  AST_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_en && stat_wr_req && wel && !busy) |-> stat_wr_ok);            // R6
  AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == PROT_ALL) |-> !arr_wr_ok);                                    // R5
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!arr_wr_ok && !stat_wr_ok));                                // R9
  AST_WRITE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_ok || stat_wr_ok) |=> !status_byte[1]);                       // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status_byte[6:4]) == 0);                                   // R2

endmodule

// File: tb/test_eeprom_wrguard.sv
module test_eeprom_wrguard;

  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wren_req = 0, wrdi_req = 0, stat_wr_req = 0, arr_wr_req = 0;
  logic [7:0]    stat_wr_data = 0;
  logic [AW-1:0] arr_addr = 0;
  logic          wp_n = 1, busy = 0;
  logic [7:0]    status_byte;
  logic          arr_wr_ok, stat_wr_ok;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  // model state
  logic       m_wel  = 0;
  logic [1:0] m_lvl  = 2'b01;
  logic       m_lock = 0;

  always #2 clk = ~clk;   // 250 MHz

  eeprom_wrguard #(.ADDR_W(AW), .RST_LVL(eeprom_wrguard_pkg::PROT_QUARTER), .RST_LOCK(1'b0))
  i_eeprom_wrguard (
    .clk(clk), .rst_n(rst_n), .wren_req(wren_req), .wrdi_req(wrdi_req),
    .stat_wr_req(stat_wr_req), .stat_wr_data(stat_wr_data), .arr_wr_req(arr_wr_req),
    .arr_addr(arr_addr), .wp_n(wp_n), .busy(busy), .status_byte(status_byte),
    .arr_wr_ok(arr_wr_ok), .stat_wr_ok(stat_wr_ok)
  );

  function automatic bit is_prot(input logic [1:0] lvl, input int addr);
    if (lvl == 2'b00) return 0;
    if (lvl == 2'b01) return addr >= 12288;
    if (lvl == 2'b10) return addr >= 8192;
    return 1;
  endfunction

  task automatic check(input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
    end
  endtask

  // one cycle: drive after negedge, compare, advance model at posedge
  task automatic cyc(input logic en, input logic di, input logic sw, input logic [7:0] sd,
                     input logic aw, input int ad, input logic wp, input logic bz);
    logic e_sok, e_aok;
    logic [7:0] e_stat;
    wren_req = en; wrdi_req = di; stat_wr_req = sw; stat_wr_data = sd;
    arr_wr_req = aw; arr_addr = AW'(ad); wp_n = wp; busy = bz;
    #1;
    e_stat = {m_lock, 3'b000, m_lvl, m_wel, bz};
    e_sok  = sw && m_wel && !bz && !(m_lock && !wp);
    e_aok  = aw && m_wel && !bz && !is_prot(m_lvl, ad);
    check("status_byte", status_byte, e_stat);
    check("stat_wr_ok", stat_wr_ok, e_sok);
    check("arr_wr_ok", arr_wr_ok, e_aok);
    @(posedge clk);
    if (e_sok) begin m_lvl = sd[3:2]; m_lock = sd[7]; end
    if (e_sok || e_aok) m_wel = 0;
    else if (!bz) begin
      if (di) m_wel = 0;
      else if (en) m_wel = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle();          cyc(0,0,0,8'h00,0,0,1,0); endtask
  task automatic wren();          cyc(1,0,0,8'h00,0,0,1,0); endtask
  task automatic swr(input logic [7:0] d, input logic wp); cyc(0,0,1,d,0,0,wp,0); endtask
  task automatic awr(input int a); cyc(0,0,0,8'h00,1,a,1,0); endtask

  initial begin
    logic [15:0] lfsr;
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check("status_in_reset", status_byte, 8'h04);
    rst_n = 1'b1;
    @(negedge clk);
    idle();

    // R3: latch set/clear, priority, busy ignore
    cur_req = "R3";
    wren(); idle();
    cyc(0,1,0,0,0,0,1,0); idle();
    wren(); cyc(1,1,0,0,0,0,1,0); idle();
    cyc(1,0,0,0,0,0,1,1); idle();
    wren(); cyc(0,1,0,0,0,0,1,1); idle();

    // R9: busy blocks both writes with latch set
    cur_req = "R9";
    cyc(0,0,1,8'h0C,0,0,1,1); cyc(0,0,0,0,1,0,1,1); idle();

    // R2: layout with everything set
    cur_req = "R2";
    swr(8'h8C, 1); wren(); cyc(0,0,0,0,0,0,1,1);
    // R8: refused write keeps latch (full array protected)
    cur_req = "R8";
    awr(16'h0000); idle(); awr(16'h0000); idle();

    // R7: only bits 3:2 and 7 taken; lock bit cleared again
    cur_req = "R7";
    wren(); swr(8'h72, 1); idle();

    // R5: each level against boundary addresses
    cur_req = "R5";
    for (int lv = 0; lv < 4; lv++) begin
      int addrs[6] = '{0, 8191, 8192, 12287, 12288, 16383};
      wren(); swr(8'(lv << 2), 1);
      foreach (addrs[k]) begin wren(); awr(addrs[k]); idle(); end
    end

    // R4: array write without latch is refused
    cur_req = "R4";
    swr(8'h00, 1); wren(); swr(8'h00, 1); awr(100); wren(); awr(100); idle();

    // R6: pin ignored when lock bit clear, blocks when set
    cur_req = "R6";
    wren(); swr(8'h00, 0); idle();
    wren(); swr(8'h80, 1); idle();
    wren(); swr(8'h00, 0); idle();
    swr(8'h00, 1); idle();

    // random mix, one write kind per cycle
    cur_req = "R8";
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = lfsr[2:0];
      cyc(op == 0 || op == 5, op == 1, op == 2, {lfsr[15], 3'b101, lfsr[9:8], 2'b11},
          op == 3 || op == 4, int'(lfsr[13:0]) ^ int'({lfsr[3:0], 10'h0}),
          lfsr[11] | lfsr[6], lfsr[7] & lfsr[4]);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule